// File: doc/BRIEF.md
# Supply start-up and line qualification sequencer

This block decides when a primary-side switching controller may start switching, and which charge current its high-voltage start-up source should feed into the supply capacitor. It sees only digitized comparator flags for the supply rail and the rectified line: supply above 3 V, supply at the start threshold, supply at or below the maintain level, supply below UVLO, line above the brown-in level and line below the brown-out level. It also takes a fault shutdown request from the protection logic and a flag that says whether burst mode has paused switching.

From these flags a three-state sequencer (charging, running, halted after fault) produces a 2-bit charge-current select and a run-enable. Line brown-in and brown-out are qualified by two consecutive-sample timers whose lengths are parameters given in clock cycles. A fault remembers itself: once the supply collapses after a fault, recharging uses the reduced fault current until the start threshold is reached again.

Top module: `hv_startup_seq`

## Requirements
- R1: During reset and right after it the sequencer is in the charging state with no fault history: run_en is 0 and chg_sel follows R2 to R4.
- R2: In the charging state with no fault history and the supply not yet at the start threshold, chg_sel is 01 (low current) while sup_above_3v is 0.
- R3: In the charging state with no fault history, chg_sel is 10 (high current) while sup_above_3v is 1 and the supply is below the start threshold.
- R4: In the charging state, chg_sel is 00 (off) whenever sup_at_start is 1, whatever the fault history.
- R5: Brown-in is qualified after line_above_bi has been sampled high on BRIN_CYCLES consecutive rising edges; run_en rises on the following edge if sup_at_start is 1 then, and never while sup_at_start is 0.
- R6: Any single low sample of line_above_bi restarts the brown-in count from zero.
- R7: While running, line_below_bo sampled high on BROUT_CYCLES consecutive edges drops run_en on the last of those edges; a low sample restarts that count; run_en then stays 0 until a new brown-in is qualified.
- R8: A fault_req sampled high stops switching on that edge: run_en is 0 and chg_sel is 00 until sup_below_uvlo is sampled high.
- R9: After a fault, once the supply has fallen below UVLO, chg_sel is 11 (fault current) regardless of sup_above_3v until sup_at_start, after which the next brown-in qualified start clears the fault history.
- R10: While running, chg_sel is 10 when both burst_on and sup_at_maint are 1 and 00 otherwise; run_en is unaffected.
- R11: While running, sup_below_uvlo sampled high drops run_en on that edge and returns to normal charging (01 or 10, not 11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_above_3v | input | 1 | Supply above 3 V |
| sup_at_start | input | 1 | Supply at or above the start threshold |
| sup_at_maint | input | 1 | Supply at or below the maintain level |
| sup_below_uvlo | input | 1 | Supply below UVLO |
| line_above_bi | input | 1 | Line above the brown-in level |
| line_below_bo | input | 1 | Line below the brown-out level |
| fault_req | input | 1 | Fault shutdown request |
| burst_on | input | 1 | Burst mode has paused switching |
| chg_sel | output | 2 | Charge current: 00 off, 01 low, 10 high, 11 fault |
| run_en | output | 1 | Switching permitted |

## Verification
The hardest situation to reach is fault-current recharge followed by a clean restart: it needs a running state, a fault, a supply collapse below UVLO and a new start, all while brown-in stays qualified. The bench walks through that chain in order, driving the supply flags as the rail would move, and then forces UVLO from the run state to show that the fault history was cleared. Timer restarts are swept for every interruption point inside the brown-in window with short timer parameters.

// File: rtl/hv_startup_seq.sv
module hv_startup_seq #(
  parameter int BRIN_CYCLES  = 5000,
  parameter int BROUT_CYCLES = 2500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_above_3v,
  input  logic       sup_at_start,
  input  logic       sup_at_maint,
  input  logic       sup_below_uvlo,
  input  logic       line_above_bi,
  input  logic       line_below_bo,
  input  logic       fault_req,
  input  logic       burst_on,
  output logic [1:0] chg_sel,
  output logic       run_en
);
  localparam int BIW = $clog2(BRIN_CYCLES + 1);
  localparam int BOW = $clog2(BROUT_CYCLES + 1);
  localparam logic [BIW-1:0] BI_LAST = BIW'(BRIN_CYCLES - 1);
  localparam logic [BOW-1:0] BO_LAST = BOW'(BROUT_CYCLES - 1);
  localparam logic [1:0] CS_OFF = 2'b00, CS_LOW = 2'b01, CS_HIGH = 2'b10, CS_FLT = 2'b11;

  typedef enum logic [1:0] {ST_CHG, ST_RUN, ST_HALT} st_t;
  st_t st, st_nx;

  logic [BIW-1:0] bi_cnt;
  logic [BOW-1:0] bo_cnt;
  logic bi_ok, flt_hist;

  wire bi_fire = line_above_bi && (bi_cnt == BI_LAST);
  wire bo_fire = line_below_bo && (bo_cnt == BO_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bi_cnt <= '0;
      bo_cnt <= '0;
      bi_ok  <= 1'b0;
    end else begin
      if (!line_above_bi) bi_cnt <= '0;
      else if (bi_cnt != BI_LAST) bi_cnt <= bi_cnt + 1'b1;
      if (!line_below_bo) bo_cnt <= '0;
      else if (bo_cnt != BO_LAST) bo_cnt <= bo_cnt + 1'b1;
      if (bo_fire) bi_ok <= 1'b0;
      else if (bi_fire) bi_ok <= 1'b1;
    end
  end

  always_comb begin
    st_nx = st;
    case (st)
      ST_CHG:  if (fault_req) st_nx = ST_HALT;
               else if (sup_at_start && bi_ok) st_nx = ST_RUN;
      ST_RUN:  if (fault_req) st_nx = ST_HALT;
               else if (sup_below_uvlo || bo_fire) st_nx = ST_CHG;
      ST_HALT: if (sup_below_uvlo) st_nx = ST_CHG;
      default: st_nx = ST_CHG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_CHG;
      flt_hist <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == ST_HALT && st_nx == ST_CHG) flt_hist <= 1'b1;
      else if (st == ST_CHG && st_nx == ST_RUN) flt_hist <= 1'b0;
    end
  end

  assign run_en = (st == ST_RUN);

  always_comb begin
    chg_sel = CS_OFF;
    case (st)
      ST_CHG:  if (!sup_at_start)
                 chg_sel = flt_hist ? CS_FLT : (sup_above_3v ? CS_HIGH : CS_LOW);
      ST_RUN:  if (burst_on && sup_at_maint) chg_sel = CS_HIGH;
      default: chg_sel = CS_OFF;
    endcase
  end

  assert_start_needed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> $past(sup_at_start));
  assert_no_charge_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && sup_at_start) |-> (chg_sel == CS_OFF));
  assert_fault_cur_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_sel == CS_FLT) |-> !run_en);
  assert_fault_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |=> !run_en);
  assert_brownout_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && line_below_bo && bo_cnt == BO_LAST) |=> !run_en);
  assert_uvlo_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && sup_below_uvlo) |=> (!run_en && chg_sel != CS_FLT));
  assert_low_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !sup_above_3v && chg_sel != CS_OFF) |-> (chg_sel != CS_HIGH));
endmodule

// File: tb/hv_startup_seq_tb.sv
module hv_startup_seq_tb_top;
  localparam int BRIN  = 8;
  localparam int BROUT = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic g3 = 0, gs = 0, mt = 0, uv = 0, la = 0, lb = 0, fr = 0, bu = 0;
  logic [1:0] chg_sel;
  logic run_en;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  hv_startup_seq #(.BRIN_CYCLES(BRIN), .BROUT_CYCLES(BROUT)) dut_i (
    .clk(clk), .rst_n(rst_n), .sup_above_3v(g3), .sup_at_start(gs),
    .sup_at_maint(mt), .sup_below_uvlo(uv), .line_above_bi(la),
    .line_below_bo(lb), .fault_req(fr), .burst_on(bu),
    .chg_sel(chg_sel), .run_en(run_en));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; g3 = 0; gs = 0; mt = 0; uv = 0; la = 0; lb = 0; fr = 0; bu = 0;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  task automatic go_run();
    do_reset();
    g3 = 1; gs = 1; la = 1;
    step(BRIN + 1);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 run_en in reset", run_en, 0);
    chk("R1 chg_sel in reset", chg_sel, 1);
    do_reset();
    chk("R1 run_en after reset", run_en, 0);

    for (int a = 0; a < 2; a++)
      for (int s = 0; s < 2; s++) begin
        g3 = a[0]; gs = s[0];
        step(1);
        if (s == 1) chk("R4 off at start", chg_sel, 0);
        else if (a == 1) chk("R3 high above 3V", chg_sel, 2);
        else chk("R2 low below 3V", chg_sel, 1);
      end

    do_reset();
    g3 = 1; gs = 0; la = 1;
    step(BRIN + 3);
    chk("R5 no run below start", run_en, 0);
    gs = 1;
    step(1);
    chk("R5 run once start reached", run_en, 1);

    for (int k = 1; k < BRIN; k++) begin
      do_reset();
      g3 = 1; gs = 1; la = 1;
      step(k);
      la = 0;
      step(1);
      la = 1;
      step(BRIN);
      chk("R6 count restarted", run_en, 0);
      step(1);
      chk("R5 run after qualify", run_en, 1);
    end

    go_run();
    la = 0; lb = 1;
    step(BROUT - 1);
    chk("R7 still running", run_en, 1);
    lb = 0;
    step(1);
    lb = 1;
    step(BROUT - 1);
    chk("R7 brown-out count restarted", run_en, 1);
    step(1);
    chk("R7 brown-out drop", run_en, 0);
    lb = 0;
    step(20);
    chk("R7 stays off without brown-in", run_en, 0);
    la = 1;
    step(BRIN);
    chk("R7 needs full brown-in", run_en, 0);
    step(1);
    chk("R7 restart after brown-in", run_en, 1);

    for (int b = 0; b < 2; b++)
      for (int m = 0; m < 2; m++) begin
        bu = b[0]; mt = m[0];
        step(1);
        chk("R10 maintain select", chg_sel, (b == 1 && m == 1) ? 2 : 0);
        chk("R10 run kept", run_en, 1);
      end
    bu = 0; mt = 0;

    fr = 1; gs = 0;
    step(1);
    fr = 0;
    chk("R8 fault stops run", run_en, 0);
    chk("R8 no charge after fault", chg_sel, 0);
    step(5);
    chk("R8 stays off above UVLO", chg_sel, 0);
    uv = 1; g3 = 0;
    step(1);
    chk("R9 fault current", chg_sel, 3);
    uv = 0;
    step(2);
    chk("R9 fault current below 3V", chg_sel, 3);
    g3 = 1;
    step(1);
    chk("R9 fault current above 3V", chg_sel, 3);
    chk("R9 no run during recharge", run_en, 0);
    gs = 1;
    #1;
    chk("R4 off at start after fault", chg_sel, 0);
    step(1);
    chk("R9 restart after recharge", run_en, 1);
    gs = 0; uv = 1;
    step(1);
    chk("R11 UVLO drops run", run_en, 0);
    chk("R11 normal charge after UVLO", chg_sel, 2);
    uv = 0; g3 = 0;
    #1;
    chk("R11 low current, history clear", chg_sel, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule